// File: doc/BRIEF.md
# Block-Transfer Address Sequencer with Self-Reload

This block is the address engine of one channel of a block-move engine. A block is F frames of E elements each. For every element the channel shows a source word address and a destination word address, and it advances by one element for each accepted handshake. Each side has its own post-modify rule: add one, subtract one, or add a signed index register. With these rules the same engine can walk linear buffers, reversed buffers, strided buffers and circular buffers.

A plain CPU-side write port loads the working registers while the channel is idle, and it can load a second set of reload registers at any time. If self-reload is on, the final element of a block copies the reload set into the working set in the same clock edge, and the next block starts with no software action. The reload set is not consumed, so one write gives endlessly repeating blocks.

The element handshake is valid/ready. `xfer_valid` is high whenever the channel is busy. A transfer happens on a rising edge where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low the channel waits with its addresses held steady, so there is no limit on back-pressure.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, `busy`, `xfer_valid` and `block_done` are 0, and both addresses are 0.
- R2: The register selects are: 0 source address, 1 destination address, 2 elements per frame, 3 frames per block, 4 control, 5 source index, 6 destination index, 8 to 11 reload source, reload destination, reload elements and reload frames. Control bits [1:0] hold the source mode, bits [3:2] the destination mode, bit 4 turns self-reload on, and bit 5 starts the channel. A control write with bit 5 set while idle makes `busy` and `xfer_valid` high from the next cycle.
- R3: The addresses shown are the values before the update. They change only on an edge where valid and ready are both high, and they hold steady while `xfer_ready` is low.
- R4: Mode 00 adds 1 to the address after each element, wrapping from FFFF to 0000.
- R5: Mode 01 subtracts 1 from the address after each element, wrapping from 0000 to FFFF.
- R6: Modes 10 and 11 add the side's 16-bit index register after each element, modulo 2^16.
- R7: A block takes exactly E×F accepted elements, with E and F taken from selects 2 and 3. `block_done` is high only while the final element's handshake is being accepted.
- R8: If self-reload is off, `busy` and `xfer_valid` drop after the final element. Later `xfer_ready` pulses are ignored, and the addresses stay at their post-modify values.
- R9: If self-reload is on, `busy` stays high after the final element. The next block starts from the reload source address, reload destination address, reload element count and reload frame count.
- R10: A write to a reload register during a block does not change the addresses or the length of that block.
- R11: The reload registers are kept after a reload, so every later block repeats the same start values and length.
- R12: While busy, writes to selects 0 to 6 (working registers and control) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| xfer_valid | output | 1 | An element address pair is on offer |
| xfer_ready | input | 1 | The element is accepted on this edge |
| src_addr | output | ADDR_W | Source address of the current element |
| dst_addr | output | ADDR_W | Destination address of the current element |
| block_done | output | 1 | The final element of the block is being accepted |
| busy | output | 1 | The channel is running |

## Verification
The bench sweeps every mode pair over every shape from 1×1 to 3×3, starting from addresses next to the wrap points and using a negative index. A design with a wrong carry or a wrong sign would therefore produce wrong addresses within two elements. Ready is held low on alternate elements, so an engine that advanced without a handshake, or that showed the address after the update, drifts off by one step. A second test rewrites the reload set and the working registers in the middle of a block, then runs three self-reloaded blocks. This catches a reload taken too early, working writes that slip through while busy, a reload set cleared after use, and a counter that reloads the wrong per-frame length.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    STEP_INC  = 2'b00,
    STEP_DEC  = 2'b01,
    STEP_IDX  = 2'b10,
    STEP_IDX2 = 2'b11
  } step_mode_e;

  typedef enum logic [3:0] {
    SEL_SRC      = 4'd0,
    SEL_DST      = 4'd1,
    SEL_ELEM     = 4'd2,
    SEL_FRAME    = 4'd3,
    SEL_CTRL     = 4'd4,
    SEL_SRC_IDX  = 4'd5,
    SEL_DST_IDX  = 4'd6,
    SEL_RL_SRC   = 4'd8,
    SEL_RL_DST   = 4'd9,
    SEL_RL_ELEM  = 4'd10,
    SEL_RL_FRAME = 4'd11
  } reg_sel_e;

  localparam int CTRL_AUTO_BIT  = 4;
  localparam int CTRL_START_BIT = 5;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  step_mode_e   mode,
  input  logic [W-1:0] index,
  output logic [W-1:0] addr
);
  logic [W-1:0] delta;

  always_comb begin
    unique case (mode)
      STEP_INC: delta = W'(1);
      STEP_DEC: delta = '1;
      default:  delta = index;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load_en) addr <= load_val;
    else if (step_en) addr <= addr + delta;
  end
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] elem_load,
  input  logic [CNT_W-1:0] frame_load,
  input  logic [CNT_W-1:0] elem_per_frame,
  input  logic             step_en,
  output logic             last_elem,
  output logic             last_frame
);
  logic [CNT_W-1:0] elem_left;
  logic [CNT_W-1:0] frame_left;

  assign last_elem  = (elem_left  <= CNT_W'(1));
  assign last_frame = (frame_left <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_left  <= '0;
      frame_left <= '0;
    end else if (load_en) begin
      elem_left  <= elem_load;
      frame_left <= frame_load;
    end else if (step_en) begin
      if (last_elem) begin
        elem_left  <= elem_per_frame;
        frame_left <= frame_left - CNT_W'(1);
      end else begin
        elem_left  <= elem_left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              block_done,
  output logic              busy
);
  localparam int SIDES = 2;

  logic              enable, auto_en;
  step_mode_e        src_mode, dst_mode;
  logic [ADDR_W-1:0] src_idx, dst_idx, rl_src, rl_dst;
  logic [CNT_W-1:0]  elem_cfg, frame_cfg, rl_elem, rl_frame;
  logic              wr_work, wr_any, start, grant, reload;
  logic              last_elem, last_frame;

  assign wr_any  = cfg_we;
  assign wr_work = cfg_we && !enable;
  assign start   = wr_work && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_START_BIT];
  assign grant   = enable && xfer_ready;
  assign block_done = grant && last_elem && last_frame;
  assign reload  = block_done && auto_en;

  assign xfer_valid = enable;
  assign busy       = enable;

  // working configuration, writable only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      auto_en   <= 1'b0;
      src_mode  <= STEP_INC;
      dst_mode  <= STEP_INC;
      src_idx   <= '0;
      dst_idx   <= '0;
      elem_cfg  <= '0;
      frame_cfg <= '0;
    end else begin
      if (wr_work) begin
        unique case (cfg_sel)
          SEL_ELEM:    elem_cfg  <= cfg_wdata[CNT_W-1:0];
          SEL_FRAME:   frame_cfg <= cfg_wdata[CNT_W-1:0];
          SEL_SRC_IDX: src_idx   <= cfg_wdata;
          SEL_DST_IDX: dst_idx   <= cfg_wdata;
          SEL_CTRL: begin
            src_mode <= step_mode_e'(cfg_wdata[1:0]);
            dst_mode <= step_mode_e'(cfg_wdata[3:2]);
            auto_en  <= cfg_wdata[CTRL_AUTO_BIT];
          end
          default: ;
        endcase
      end
      if (start) begin
        enable <= 1'b1;
      end else if (block_done && !auto_en) begin
        enable <= 1'b0;
      end
      if (reload) begin
        elem_cfg  <= rl_elem;
        frame_cfg <= rl_frame;
      end
    end
  end

  // reload set, writable at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_src   <= '0;
      rl_dst   <= '0;
      rl_elem  <= '0;
      rl_frame <= '0;
    end else if (wr_any) begin
      unique case (cfg_sel)
        SEL_RL_SRC:   rl_src   <= cfg_wdata;
        SEL_RL_DST:   rl_dst   <= cfg_wdata;
        SEL_RL_ELEM:  rl_elem  <= cfg_wdata[CNT_W-1:0];
        SEL_RL_FRAME: rl_frame <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // per-side address units
  logic              side_load [SIDES];
  logic [ADDR_W-1:0] side_lval [SIDES];
  step_mode_e        side_mode [SIDES];
  logic [ADDR_W-1:0] side_idx  [SIDES];
  logic [ADDR_W-1:0] side_addr [SIDES];

  assign side_load[0] = reload || (wr_work && cfg_sel == SEL_SRC);
  assign side_load[1] = reload || (wr_work && cfg_sel == SEL_DST);
  assign side_lval[0] = reload ? rl_src : cfg_wdata;
  assign side_lval[1] = reload ? rl_dst : cfg_wdata;
  assign side_mode[0] = src_mode;
  assign side_mode[1] = dst_mode;
  assign side_idx[0]  = src_idx;
  assign side_idx[1]  = dst_idx;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_addr_step #(.W(ADDR_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (side_load[g]),
      .load_val (side_lval[g]),
      .step_en  (grant),
      .mode     (side_mode[g]),
      .index    (side_idx[g]),
      .addr     (side_addr[g])
    );
  end

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];

  dma_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_en        (start || reload),
    .elem_load      (reload ? rl_elem  : elem_cfg),
    .frame_load     (reload ? rl_frame : frame_cfg),
    .elem_per_frame (elem_cfg),
    .step_en        (grant),
    .last_elem      (last_elem),
    .last_frame     (last_frame)
  );
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              block_done,
  input logic              busy,
  input logic              auto_en,
  input logic [1:0]        src_mode,
  input logic [1:0]        dst_mode
);
  p_done_on_handshake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> (xfer_valid && xfer_ready));

  p_stop_without_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (block_done && !auto_en) |=> !busy);

  p_stay_busy_on_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (block_done && auto_en) |=> busy);

  p_hold_when_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_ready) |=> ($stable(src_addr) && $stable(dst_addr)));

  p_src_increment_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !block_done && src_mode == 2'b00)
      |=> src_addr == ADDR_W'($past(src_addr) + 1'b1));

  p_dst_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !block_done && dst_mode == 2'b01)
      |=> dst_addr == ADDR_W'($past(dst_addr) - 1'b1));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .src_addr   (src_addr),
  .dst_addr   (dst_addr),
  .block_done (block_done),
  .busy       (busy),
  .auto_en    (auto_en),
  .src_mode   (src_mode),
  .dst_mode   (dst_mode)
);

// File: tb/test_dma_addr_seq.sv
`timescale 1ns/100ps
module test_dma_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        xfer_ready = 1'b0;
  logic        xfer_valid, block_done, busy;
  logic [15:0] src_addr, dst_addr;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  dma_addr_seq i_dma_addr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .src_addr(src_addr), .dst_addr(dst_addr), .block_done(block_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #0.5;
    cfg_we = 1'b0;
  endtask

  // one accepted element: addresses are checked before the edge
  task automatic grant(input logic [15:0] es, input logic [15:0] ed, input bit edone);
    @(negedge clk);
    xfer_ready = 1'b1;
    #0.5;
    chk(xfer_valid == 1'b1, "R2 valid", 32'(xfer_valid), 1);
    chk(src_addr == es, "R3 source address", 32'(src_addr), 32'(es));
    chk(dst_addr == ed, "R3 destination address", 32'(dst_addr), 32'(ed));
    chk(block_done == edone, "R7 block_done", 32'(block_done), 32'(edone));
    @(posedge clk); #0.5;
    xfer_ready = 1'b0;
  endtask

  task automatic stall(input logic [15:0] es, input logic [15:0] ed);
    @(negedge clk);
    xfer_ready = 1'b0;
    @(posedge clk); #0.5;
    chk(src_addr == es && dst_addr == ed, "R3 hold under back-pressure",
        {src_addr, dst_addr}, {es, ed});
    chk(block_done == 1'b0, "R7 no done while stalled", 32'(block_done), 0);
  endtask

  function automatic logic [15:0] step_of(input int mode, input logic [15:0] idx);
    if (mode == 0) return 16'h0001;
    if (mode == 1) return 16'hFFFF;
    return idx;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    // R1 reset state
    chk(busy == 0 && xfer_valid == 0, "R1 busy/valid", {busy, xfer_valid}, 0);
    chk(block_done == 0, "R1 block_done", 32'(block_done), 0);
    chk(src_addr == 0 && dst_addr == 0, "R1 addresses", {src_addr, dst_addr}, 0);
    @(negedge clk); rst_n = 1'b1;

    // sweep: R2 R4 R5 R6 R7 R8 over modes and shapes
    for (int sm = 0; sm < 4; sm++) begin
      for (int dm = 0; dm < 4; dm++) begin
        for (int e = 1; e <= 3; e++) begin
          for (int f = 1; f <= 3; f++) begin
            logic [15:0] ss, ds, si, di, sst, dst_s;
            int n;
            ss = 16'hFFFE; ds = 16'h0001; si = 16'h0003; di = 16'hFFFE;
            sst = step_of(sm, si); dst_s = step_of(dm, di);
            n = e * f;
            wr(4'd0, ss); wr(4'd1, ds); wr(4'd2, 16'(e)); wr(4'd3, 16'(f));
            wr(4'd5, si); wr(4'd6, di);
            chk(busy == 1'b0, "R2 idle before start", 32'(busy), 0);
            wr(4'd4, 16'h0020 | 16'(dm << 2) | 16'(sm));
            chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
            for (int k = 0; k < n; k++) begin
              logic [15:0] es, ed;
              es = ss + 16'(k) * sst;
              ed = ds + 16'(k) * dst_s;
              if (k % 2 == 1) stall(es, ed);
              // R4 R5 R6: address k equals start + k*step modulo 2^16
              grant(es, ed, k == n - 1);
            end
            chk(busy == 1'b0 && xfer_valid == 1'b0, "R8 stops after block",
                {busy, xfer_valid}, 0);
            @(negedge clk); xfer_ready = 1'b1; #0.5;
            chk(block_done == 1'b0, "R8 ready ignored when idle", 32'(block_done), 0);
            @(posedge clk); #0.5; xfer_ready = 1'b0;
            chk(src_addr == 16'(ss + 16'(n) * sst) && dst_addr == 16'(ds + 16'(n) * dst_s),
                "R8 final post-modify addresses", {src_addr, dst_addr},
                {16'(ss + 16'(n) * sst), 16'(ds + 16'(n) * dst_s)});
          end
        end
      end
    end

    // self-reload: R9 R10 R11 R12
    wr(4'd0, 16'h1000); wr(4'd1, 16'h2000); wr(4'd2, 16'd2); wr(4'd3, 16'd2);
    wr(4'd5, 16'h0010);
    wr(4'd4, 16'h0030 | 16'(1 << 2) | 16'd2);  // src index, dst decrement, auto
    grant(16'h1000, 16'h2000, 1'b0);
    wr(4'd8, 16'h4000); wr(4'd9, 16'h5000); wr(4'd10, 16'd3); wr(4'd11, 16'd1);
    wr(4'd0, 16'hAAAA); wr(4'd1, 16'hBBBB); wr(4'd2, 16'd7); wr(4'd5, 16'h0100);
    wr(4'd4, 16'h0000);
    // R10 R12: block continues unchanged
    grant(16'h1010, 16'h1FFF, 1'b0);
    grant(16'h1020, 16'h1FFE, 1'b0);
    grant(16'h1030, 16'h1FFD, 1'b1);
    chk(busy == 1'b1, "R9 busy kept after reload", 32'(busy), 1);
    for (int b = 0; b < 2; b++) begin
      // R9 first reloaded block, R11 repeat
      grant(16'h4000, 16'h5000, 1'b0);
      stall(16'h4010, 16'h4FFF);
      grant(16'h4010, 16'h4FFF, 1'b0);
      grant(16'h4020, 16'h4FFE, 1'b1);
      chk(busy == 1'b1, "R11 busy across repeated blocks", 32'(busy), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule